// File: doc/BRIEF.md
# Tri-State PWM Gate Sequencer

This block turns a three-level PWM command into the high-side and low-side gate enables of a synchronous buck power stage. The analog front end supplies sampled flags for the three PWM levels, an active-low brake request, a supply-good flag, a zero-current comparator output, and one feedback flag per gate that reads high while that gate's voltage is below its threshold. The sequencer produces gate enables that never overlap. It also holds an operating mode that is latched at power-up.

A command of high drives the high-side gate and a command of low drives the low-side gate. A mid-level command always drops the high-side gate. What happens to the low-side gate depends on the latched mode:
- In brake mode the low-side gate drops at once.
- In diode-emulation mode the low-side gate conducts until the inductor current reaches zero, and then releases.

Diode-emulation mode is chosen by pulling the brake input low at least once while supply-good is asserted. The mode is then held until supply-good falls. The zero-current comparator is blanked for a programmable number of cycles after the low-side gate rises. A cycle-counted timeout releases the low-side gate if zero current is never seen.

Top module: `pwm_gate_seq`

## Requirements
- R1: With exactly one of the level flags set, pwm_hi_i requests the high-side gate and pwm_lo_i requests the low-side gate. A gate is enabled one cycle after its request, provided the other gate is already off.
- R2: A mid-level command clears hs_en_o on the next clock edge.
- R3: When dem_mode_o is 0, a mid-level command also clears ls_en_o on the next edge, and both gates then stay off.
- R4: When dem_mode_o is 1, a mid-level command keeps the low-side gate on until a zero-current detection is accepted. ls_en_o falls on the edge that accepts the detection. It then stays low until the command leaves the mid level.
- R5: dem_mode_o is set when the synchronized brake input is low while supply_ok_i is 1. This happens three edges after brake_ni falls. A brake that is low while supply_ok_i is 0 does not set the mode.
- R6: Once set, dem_mode_o stays set whatever the brake and PWM inputs do. It clears on the first edge at which supply_ok_i is 0.
- R7: brake_ni low forces both enables to 0 on the third rising edge after it is driven low. The delay comes from the two-flop synchronizer plus the output register.
- R8: zc_i is ignored until BLANK_CYC edges have passed with ls_fb_low_i at 0 after the low-side gate rose.
- R9: In diode-emulation mode, if no zero current is accepted, ls_en_o falls on the edge TMO_CYC+1 edges after the mid-level command is first sampled.
- R10: hs_en_o and ls_en_o are never both 1. A gate turns on only at an edge where the other enable was 0 and the other gate's feedback-low flag was 1.
- R11: supply_ok_i at 0 clears both enables on the next edge.
- R12: Any level-flag pattern other than exactly one of pwm_hi_i or pwm_lo_i set is decoded as the mid level. This covers no flag set, two or more flags set, and pwm_mid_i set.
- R13: While rst_ni is low, both enables and dem_mode_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_hi_i | input | 1 | PWM sampled at high level |
| pwm_lo_i | input | 1 | PWM sampled at low level |
| pwm_mid_i | input | 1 | PWM sampled at mid (tri-state) level |
| brake_ni | input | 1 | Brake request, active low, asynchronous |
| supply_ok_i | input | 1 | Supply above undervoltage threshold |
| zc_i | input | 1 | Zero-current comparator output |
| hs_fb_low_i | input | 1 | High-side gate voltage below threshold |
| ls_fb_low_i | input | 1 | Low-side gate voltage below threshold |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| dem_mode_o | output | 1 | Diode-emulation mode latched |

## Verification
The bench targets the exact edge on which each release happens. A zero-current flag that arrives during blanking must not drop the low-side gate. A design that skipped blanking would release at once. A design that counted the window from the command instead of from the gate rise would release early.

The timeout is checked one edge before and one edge after it fires, which catches off-by-one counters. A held feedback flag must stall the opposite gate; a design without the non-overlap handshake would turn it on early.

The latched mode must survive later brake pulses and clear only on a supply drop. Illegal flag combinations must fall back to the mid-level action rather than drive a gate.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
  typedef enum logic [1:0] {
    CMD_LO  = 2'd0,
    CMD_HI  = 2'd1,
    CMD_MID = 2'd2
  } pwm_cmd_e;
endpackage

// File: rtl/pwm_level_decode.sv
module pwm_level_decode
  import pwm_gate_pkg::*;
(
  input  logic     hi_i,
  input  logic     lo_i,
  input  logic     mid_i,
  output pwm_cmd_e cmd_o
);
  // only a clean single high or low flag drives a gate; all else is mid (R12)
  always_comb begin
    case ({hi_i, lo_i, mid_i})
      3'b100:  cmd_o = CMD_HI;
      3'b010:  cmd_o = CMD_LO;
      default: cmd_o = CMD_MID;
    endcase
  end
endmodule

// File: rtl/pwm_brake_sync.sv
module pwm_brake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pwm_dem_timer.sv
module pwm_dem_timer #(
  parameter int BLANK_CYC = 15,
  parameter int TMO_CYC   = 3000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic zc_i,
  input  logic ls_fb_low_i,
  output logic release_o
);
  localparam int BLK_W = $clog2(BLANK_CYC + 1);
  localparam int TMO_W = $clog2(TMO_CYC + 1);
  localparam logic [BLK_W-1:0] BLK_MAX = BLK_W'(BLANK_CYC);
  localparam logic [TMO_W-1:0] TMO_MAX = TMO_W'(TMO_CYC);

  logic [BLK_W-1:0] blk_q;
  logic [TMO_W-1:0] tmo_q;
  logic             zc_ok;

  // blanking window restarts whenever the low-side gate is seen low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               blk_q <= '0;
    else if (ls_fb_low_i)      blk_q <= '0;
    else if (blk_q != BLK_MAX) blk_q <= blk_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               tmo_q <= '0;
    else if (!active_i)        tmo_q <= '0;
    else if (tmo_q != TMO_MAX) tmo_q <= tmo_q + 1'b1;
  end

  assign zc_ok     = zc_i && !ls_fb_low_i && (blk_q == BLK_MAX);
  assign release_o = active_i && (zc_ok || (tmo_q == TMO_MAX));

  AST_BLANK_RESPECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ls_fb_low_i) && !release_o |=> !release_o || (tmo_q == TMO_MAX) || (BLANK_CYC == 0)); // R8
endmodule

// File: rtl/pwm_gate_drive.sv
module pwm_gate_drive
  import pwm_gate_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pwm_cmd_e cmd_i,
  input  logic     dem_i,
  input  logic     brake_i,
  input  logic     supply_ok_i,
  input  logic     release_i,
  input  logic     hs_fb_low_i,
  input  logic     ls_fb_low_i,
  output logic     hs_en_o,
  output logic     ls_en_o,
  output logic     active_o
);
  logic done_q, hs_en_q, ls_en_q;
  logic gate_ok, hs_want, ls_want;

  // low side released for the rest of this mid-level interval
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             done_q <= 1'b0;
    else if (cmd_i != CMD_MID) done_q <= 1'b0;
    else if (release_i)      done_q <= 1'b1;
  end

  assign active_o = (cmd_i == CMD_MID) && dem_i && !done_q;
  assign gate_ok  = supply_ok_i && !brake_i;
  assign hs_want  = gate_ok && (cmd_i == CMD_HI);
  assign ls_want  = gate_ok && ((cmd_i == CMD_LO) || (active_o && !release_i));

  // turn-off is immediate; turn-on waits for the opposite gate to be low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_en_q <= 1'b0;
      ls_en_q <= 1'b0;
    end else begin
      hs_en_q <= hs_want && (hs_en_q || (!ls_en_q && ls_fb_low_i));
      ls_en_q <= ls_want && (ls_en_q || (!hs_en_q && hs_fb_low_i));
    end
  end

  assign hs_en_o = hs_en_q;
  assign ls_en_o = ls_en_q;

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_en_q && ls_en_q)); // R10
  AST_HS_WAITS_LS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_q) |-> $past(!ls_en_q && ls_fb_low_i)); // R10
  AST_LS_WAITS_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ls_en_q) |-> $past(!hs_en_q && hs_fb_low_i)); // R10
  AST_MID_DROPS_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_MID) |=> !hs_en_q); // R2
  AST_BRAKE_MODE_MID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_MID) && !dem_i |=> !ls_en_q); // R3
  AST_RELEASE_DROPS_LS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> !ls_en_q); // R4
  AST_SUPPLY_LOW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !hs_en_q && !ls_en_q); // R11
endmodule

// File: rtl/pwm_gate_seq.sv
module pwm_gate_seq
  import pwm_gate_pkg::*;
#(
  parameter int BLANK_CYC   = 15,
  parameter int TMO_CYC     = 3000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_hi_i,
  input  logic pwm_lo_i,
  input  logic pwm_mid_i,
  input  logic brake_ni,
  input  logic supply_ok_i,
  input  logic zc_i,
  input  logic hs_fb_low_i,
  input  logic ls_fb_low_i,
  output logic hs_en_o,
  output logic ls_en_o,
  output logic dem_mode_o
);
  pwm_cmd_e cmd;
  logic     brake_s, dem_q, active, release_ls;

  pwm_level_decode u_dec (
    .hi_i (pwm_hi_i),
    .lo_i (pwm_lo_i),
    .mid_i(pwm_mid_i),
    .cmd_o(cmd)
  );

  pwm_brake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (brake_ni),
    .q_o   (brake_s)
  );

  // mode latch: set by a brake seen with supply good, cleared by supply loss
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          dem_q <= 1'b0;
    else if (!supply_ok_i) dem_q <= 1'b0;
    else if (!brake_s)    dem_q <= 1'b1;
  end

  pwm_dem_timer #(.BLANK_CYC(BLANK_CYC), .TMO_CYC(TMO_CYC)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .zc_i       (zc_i),
    .ls_fb_low_i(ls_fb_low_i),
    .release_o  (release_ls)
  );

  pwm_gate_drive u_drv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .dem_i      (dem_q),
    .brake_i    (!brake_s),
    .supply_ok_i(supply_ok_i),
    .release_i  (release_ls),
    .hs_fb_low_i(hs_fb_low_i),
    .ls_fb_low_i(ls_fb_low_i),
    .hs_en_o    (hs_en_o),
    .ls_en_o    (ls_en_o),
    .active_o   (active)
  );

  assign dem_mode_o = dem_q;

  AST_BRAKE_GATES_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brake_s |=> !hs_en_o && !ls_en_o); // R7
  AST_MODE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dem_q && supply_ok_i |=> dem_q); // R6
  AST_MODE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> !dem_q); // R6
  AST_MODE_NEEDS_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dem_q) |-> $past(supply_ok_i && !brake_s)); // R5
endmodule

// File: tb/pwm_gate_seq_test.sv
module pwm_gate_seq_test;
  localparam int CLK_T = 10;
  localparam int BLK   = 4;
  localparam int TMO   = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi = 1'b0, lo = 1'b1, mid = 1'b0;
  logic brake_n = 1'b1, sup = 1'b0, zc = 1'b0;
  logic hs_stuck = 1'b0, ls_stuck = 1'b0;
  logic hs_fb_low, ls_fb_low;
  logic hs_en, ls_en, dem;
  int   n_run = 0, n_fail = 0;

  always #(CLK_T/2) clk = ~clk;

  // gate voltage model: feedback follows enable unless held high
  assign hs_fb_low = hs_stuck ? 1'b0 : !hs_en;
  assign ls_fb_low = ls_stuck ? 1'b0 : !ls_en;

  pwm_gate_seq #(.BLANK_CYC(BLK), .TMO_CYC(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pwm_hi_i(hi), .pwm_lo_i(lo), .pwm_mid_i(mid),
    .brake_ni(brake_n), .supply_ok_i(sup), .zc_i(zc),
    .hs_fb_low_i(hs_fb_low), .ls_fb_low_i(ls_fb_low),
    .hs_en_o(hs_en), .ls_en_o(ls_en), .dem_mode_o(dem)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pwm(input logic h, input logic l, input logic m);
    hi = h; lo = l; mid = m;
  endtask

  // leaves the block powered with PWM low and the low-side gate on
  task automatic power_up(input logic want_dem);
    sup = 1'b0; brake_n = !want_dem; set_pwm(0, 1, 0); zc = 1'b0;
    cyc(4);
    sup = 1'b1;
    cyc(4);
    brake_n = 1'b1;
    cyc(6);
  endtask

  task automatic t_reset;
    chk("R13 hs in reset", hs_en, 1'b0);
    chk("R13 ls in reset", ls_en, 1'b0);
    chk("R13 mode in reset", dem, 1'b0);
  endtask

  task automatic t_basic;
    power_up(1'b0);
    chk("R1 ls on for low", ls_en, 1'b1);
    chk("R5 no mode without brake", dem, 1'b0);
    set_pwm(1, 0, 0);
    cyc(1);
    chk("R1 ls drops first", ls_en, 1'b0);
    chk("R10 hs waits one edge", hs_en, 1'b0);
    cyc(1);
    chk("R1 hs on for high", hs_en, 1'b1);
    set_pwm(0, 0, 1);
    cyc(1);
    chk("R2 hs off on mid", hs_en, 1'b0);
    cyc(3);
    chk("R3 ls stays off, brake mode", ls_en, 1'b0);
    set_pwm(0, 1, 0);
    cyc(2);
    set_pwm(0, 0, 1);
    cyc(1);
    chk("R3 ls off on mid, brake mode", ls_en, 1'b0);
  endtask

  task automatic t_flags;
    power_up(1'b0);
    set_pwm(1, 0, 0);
    cyc(4);
    set_pwm(1, 1, 0);
    cyc(1);
    chk("R12 hi+lo acts as mid hs", hs_en, 1'b0);
    cyc(3);
    chk("R12 hi+lo acts as mid ls", ls_en, 1'b0);
    set_pwm(0, 1, 0);
    cyc(3);
    set_pwm(0, 0, 0);
    cyc(1);
    chk("R12 no flag acts as mid", ls_en, 1'b0);
    set_pwm(1, 0, 1);
    cyc(3);
    chk("R12 hi+mid acts as mid", hs_en, 1'b0);
  endtask

  task automatic t_overlap;
    power_up(1'b0);
    ls_stuck = 1'b1;
    set_pwm(1, 0, 0);
    cyc(4);
    chk("R10 hs held while ls gate high", hs_en, 1'b0);
    ls_stuck = 1'b0;
    cyc(1);
    chk("R10 hs on once ls gate low", hs_en, 1'b1);
  endtask

  task automatic t_brake;
    power_up(1'b0);
    set_pwm(1, 0, 0);
    cyc(4);
    brake_n = 1'b0;
    cyc(2);
    chk("R7 hs still on before sync", hs_en, 1'b1);
    cyc(1);
    chk("R7 hs off by brake", hs_en, 1'b0);
    chk("R5 mode set by brake", dem, 1'b1);
    set_pwm(0, 1, 0);
    cyc(3);
    chk("R7 ls held off by brake", ls_en, 1'b0);
    brake_n = 1'b1;
  endtask

  task automatic t_mode;
    sup = 1'b0; brake_n = 1'b0;
    cyc(6);
    chk("R5 brake without supply ignored", dem, 1'b0);
    power_up(1'b1);
    chk("R5 mode latched at power-up", dem, 1'b1);
    brake_n = 1'b0; cyc(4); brake_n = 1'b1; cyc(4);
    set_pwm(1, 0, 0); cyc(3);
    chk("R6 mode survives brake and pwm", dem, 1'b1);
    sup = 1'b0;
    cyc(1);
    chk("R6 mode cleared by supply loss", dem, 1'b0);
    chk("R11 hs off on supply loss", hs_en, 1'b0);
    sup = 1'b1;
    cyc(4);
    chk("R6 mode stays clear after supply return", dem, 1'b0);
  endtask

  task automatic t_dem;
    power_up(1'b1);
    cyc(4);
    set_pwm(0, 0, 1); zc = 1'b1;
    cyc(1);
    chk("R4 ls drops on zero current", ls_en, 1'b0);
    cyc(3);
    chk("R4 ls stays off in mid", ls_en, 1'b0);
    set_pwm(1, 0, 0); zc = 1'b0;
    cyc(4);
    set_pwm(0, 0, 1); zc = 1'b1;
    cyc(2);
    chk("R4 ls turns on after high in dem mid", ls_en, 1'b1);
    cyc(BLK);
    chk("R8 zero current blanked", ls_en, 1'b1);
    cyc(1);
    chk("R8 zero current accepted after blank", ls_en, 1'b0);
    zc = 1'b0;
    set_pwm(0, 1, 0);
    cyc(3);
    set_pwm(0, 0, 1);
    cyc(TMO);
    chk("R9 ls on before timeout", ls_en, 1'b1);
    cyc(1);
    chk("R9 ls off at timeout", ls_en, 1'b0);
    cyc(5);
    chk("R4 ls stays off after timeout", ls_en, 1'b0);
    chk("R2 hs off throughout dem mid", hs_en, 1'b0);
  endtask

  initial begin
    #(CLK_T * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    sup = 1'b1; set_pwm(1, 0, 0);
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(1);
    t_basic();
    t_flags();
    t_overlap();
    t_brake();
    t_mode();
    t_dem();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule